// File: doc/BRIEF.md
# Clock Generator Power Sequencer

This block sequences the output clocks of a clock generator through power-up and power-down. After reset it keeps every output gated low and waits for an active-low power-good level. Once power-good is seen low, the block waits a settling interval, captures the frequency-select straps exactly once, and then lets each output clock through on that clock's own low phase. From then on the power-good level has no effect until the next reset.

An asynchronous active-low power-down request is brought in through two flops. The request is acted on only when it is seen low on two consecutive rising edges of the CPU complement clock. The outputs are then shut off in a fixed order, each on its own falling edge. The free-running PCI clock stops first, then the 66 MHz buffered clock, then every remaining clock. The CPU pair is parked with the true output driven high and the complement undriven, or with both tri-stated when the park select input asks for it. Only after all of this does the PLL enable drop. When the request is released, the PLL enable returns at once and the outputs come back after a restart timeout.

All source clocks are divided clocks that are sampled on one fast clock, and the block outputs gated copies of them. Drive strengths appear only as output-enable flags.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: Out of reset, every gated clock output is 0, both CPU output enables are 0, `pll_en` is 1 and `freq_sel` is 0.
- R2: Until `pg_n` is seen low, all outputs stay gated. After `pg_n` goes low there is a two-flop sync, then SETTLE_CYC cycles of waiting, and only after that does the block start enabling the outputs.
- R3: `freq_sel` is latched once, at the end of the settling interval. Bit 1 is 1 only when `s2_lvl` is 2'b01 (high). The codes 2'b00 (low) and 2'b10/2'b11 (mid) both latch 0. Bit 0 copies `s1`. Later changes to the strap inputs do not alter `freq_sel`.
- R4: Once power-good has been accepted, further changes on `pg_n` have no effect on the outputs or on `freq_sel`.
- R5: A power-down request is honoured only when the synchronized `pd_n` is low at two consecutive falling edges of `cpu_src`, which are the complement-clock rising edges. A low pulse that spans at most one such edge changes nothing.
- R6: When the request is honoured, `pcif_out` stops first, then `buf_out`, then each `oth_out` bit. Each one stops low on a falling edge of its own source that comes after the previous stage has stopped.
- R7: While parked, `cput_out` is 1 and `cpuc_oe` is 0, and `cput_oe` equals the inverse of the `park_tri` value captured at park time.
- R8: `pll_en` falls only after every gated output is low and the CPU pair is parked.
- R9: After `pd_n` is released, `pll_en` rises within 4 cycles. No output runs before RESTART_CYC cycles have passed, and all outputs run again within RESTART_CYC plus 30 cycles.
- R10: Every high pulse on a gated output has the full high time of its source. Enabling happens only while the source is low, and disabling happens only at a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (power removal) |
| pg_n | input | 1 | Active-low power-good level |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| s1 | input | 1 | Two-level frequency strap |
| s2_lvl | input | 2 | Three-level strap: 00 low, 01 high, 1x mid |
| park_tri | input | 1 | 1: tri-state both CPU outputs while parked |
| cpu_src | input | 1 | CPU true source clock |
| pcif_src | input | 1 | Free-running PCI source clock |
| buf_src | input | 1 | 66 MHz buffered source clock |
| oth_src | input | N_OTH | Remaining source clocks |
| cput_out | output | 1 | CPU true output level |
| cput_oe | output | 1 | CPU true output drive enable |
| cpuc_out | output | 1 | CPU complement output level |
| cpuc_oe | output | 1 | CPU complement drive enable |
| pcif_out | output | 1 | Gated free-running PCI clock |
| buf_out | output | 1 | Gated buffered 66 MHz clock |
| oth_out | output | N_OTH | Gated remaining clocks |
| pll_en | output | 1 | PLL and VCO enable |
| freq_sel | output | 2 | Latched strap value |

## Verification
Strap values are drawn at random, and the mid code is forced once so that it is seen to latch as zero. The straps and power-good are then disturbed after acceptance, which shows the one-time capture apart from a live copy. A two-cycle power-down pulse can cover at most one complement edge, so it separates two-edge qualification from single-edge qualification. Several full power-down cycles with random timing and a random park mode compare the last falling edges of the outputs against the required stop order, check that the PLL drops only after the last output stops, and check that the restart respects both the lower and the upper time bound. A pulse-width monitor catches any shortened high pulse at enable or at disable.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_PG,
        ST_SETTLE,
        ST_RUN,
        ST_STOP_PCIF,
        ST_STOP_BUF,
        ST_STOP_REST,
        ST_PLL_OFF,
        ST_RESTART
    } seq_state_e;

    localparam logic [1:0] STRAP_HIGH = 2'b01;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] meta_d;
    logic [W-1:0] sync_q;
    logic [W-1:0] sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/pwrseq_lane.sv
module pwrseq_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic stop_req,
    input  logic start_req,
    output logic gated,
    output logic halted
);
    typedef struct packed {
        logic en;
        logic src_prev;
        logic gated;
    } lane_t;

    lane_t lane_d;
    lane_t lane_q;

    always_comb begin
        lane_d          = lane_q;
        lane_d.src_prev = src;
        if (stop_req && lane_q.src_prev && !src) begin
            lane_d.en = 1'b0;
        end else if (start_req && !src) begin
            lane_d.en = 1'b1;
        end
        lane_d.gated = src & lane_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign gated  = lane_q.gated;
    assign halted = !lane_q.en;
endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int N_OTH       = 3,
    parameter int SETTLE_CYC  = 25000,
    parameter int RESTART_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_n,
    input  logic             pd_n,
    input  logic             s1,
    input  logic [1:0]       s2_lvl,
    input  logic             park_tri,
    input  logic             cpu_src,
    input  logic             pcif_src,
    input  logic             buf_src,
    input  logic [N_OTH-1:0] oth_src,
    output logic             cput_out,
    output logic             cput_oe,
    output logic             cpuc_out,
    output logic             cpuc_oe,
    output logic             pcif_out,
    output logic             buf_out,
    output logic [N_OTH-1:0] oth_out,
    output logic             pll_en,
    output logic [1:0]       freq_sel
);
    localparam int CNT_MAX = (SETTLE_CYC > RESTART_CYC) ? SETTLE_CYC : RESTART_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             qual;
        logic [1:0]       freq;
        logic             cpu_run;
        logic             park;
        logic             tri_sel;
        logic             pll;
        logic             cpu_prev;
        logic             cput;
        logic             cpuc;
        logic             cput_oe;
        logic             cpuc_oe;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic [1:0] sync_out;
    logic       pg_s;
    logic       pd_s;

    pwrseq_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pg_n, pd_n}),
        .dout  (sync_out)
    );
    assign pg_s = sync_out[1];
    assign pd_s = sync_out[0];

    logic             run_ph;
    logic             pcif_halted;
    logic             buf_halted;
    logic [N_OTH-1:0] oth_halted;

    assign run_ph = (seq_q.state == ST_RUN);

    pwrseq_lane u_pcif (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (pcif_src),
        .stop_req  (seq_q.state == ST_STOP_PCIF),
        .start_req (run_ph),
        .gated     (pcif_out),
        .halted    (pcif_halted)
    );

    pwrseq_lane u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (buf_src),
        .stop_req  (seq_q.state == ST_STOP_BUF),
        .start_req (run_ph),
        .gated     (buf_out),
        .halted    (buf_halted)
    );

    for (genvar gi = 0; gi < N_OTH; gi++) begin : g_oth
        pwrseq_lane u_oth (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (oth_src[gi]),
            .stop_req  (seq_q.state == ST_STOP_REST),
            .start_req (run_ph),
            .gated     (oth_out[gi]),
            .halted    (oth_halted[gi])
        );
    end

    logic cpu_rise;
    logic cpuc_rise;
    assign cpu_rise  = !seq_q.cpu_prev && cpu_src;
    assign cpuc_rise = seq_q.cpu_prev && !cpu_src;

    always_comb begin
        seq_d          = seq_q;
        seq_d.cpu_prev = cpu_src;
        case (seq_q.state)
            ST_WAIT_PG: begin
                if (!pg_s) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.cnt   = '0;
                end
            end
            ST_SETTLE: begin
                if (seq_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    seq_d.freq  = {(s2_lvl == STRAP_HIGH), s1};
                    seq_d.state = ST_RUN;
                    seq_d.qual  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (!seq_q.cpu_run && !cpu_src) begin
                    seq_d.cpu_run = 1'b1;
                    seq_d.park    = 1'b0;
                end
                if (cpuc_rise) begin
                    if (!pd_s) begin
                        if (seq_q.qual) begin
                            seq_d.state = ST_STOP_PCIF;
                            seq_d.qual  = 1'b0;
                        end else begin
                            seq_d.qual = 1'b1;
                        end
                    end else begin
                        seq_d.qual = 1'b0;
                    end
                end
            end
            ST_STOP_PCIF: begin
                if (pcif_halted) seq_d.state = ST_STOP_BUF;
            end
            ST_STOP_BUF: begin
                if (buf_halted) seq_d.state = ST_STOP_REST;
            end
            ST_STOP_REST: begin
                if ((seq_q.cpu_run && cpu_rise) || (!seq_q.cpu_run && !seq_q.park)) begin
                    seq_d.cpu_run = 1'b0;
                    seq_d.park    = 1'b1;
                    seq_d.tri_sel = park_tri;
                end
                if ((&oth_halted) && seq_q.park) begin
                    seq_d.state = ST_PLL_OFF;
                    seq_d.pll   = 1'b0;
                end
            end
            ST_PLL_OFF: begin
                if (pd_s) begin
                    seq_d.state = ST_RESTART;
                    seq_d.pll   = 1'b1;
                    seq_d.cnt   = '0;
                end
            end
            ST_RESTART: begin
                if (seq_q.cnt == CNT_W'(RESTART_CYC - 1)) begin
                    seq_d.state = ST_RUN;
                    seq_d.qual  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = ST_WAIT_PG;
        endcase
        seq_d.cput    = seq_d.cpu_run ? cpu_src : seq_d.park;
        seq_d.cpuc    = seq_d.cpu_run & !cpu_src;
        seq_d.cput_oe = seq_d.cpu_run | (seq_d.park & !seq_d.tri_sel);
        seq_d.cpuc_oe = seq_d.cpu_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_WAIT_PG;
            seq_q.pll   <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cput_out = seq_q.cput;
    assign cpuc_out = seq_q.cpuc;
    assign cput_oe  = seq_q.cput_oe;
    assign cpuc_oe  = seq_q.cpuc_oe;
    assign pll_en   = seq_q.pll;
    assign freq_sel = seq_q.freq;
endmodule

// File: rtl/clkgen_pwr_seq_chk.sv
module clkgen_pwr_seq_chk #(
    parameter int N_OTH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pg_n,
    input logic             pcif_src,
    input logic             buf_src,
    input logic             pcif_out,
    input logic             buf_out,
    input logic [N_OTH-1:0] oth_out,
    input logic             cput_out,
    input logic             cput_oe,
    input logic             cpuc_oe,
    input logic             pll_en,
    input logic [1:0]       freq_sel
);
    logic pg_seen_q;
    logic run_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_seen_q  <= 1'b0;
            run_seen_q <= 1'b0;
        end else begin
            if (!pg_n) pg_seen_q <= 1'b1;
            if (pcif_out) run_seen_q <= 1'b1;
        end
    end

    a_r2_quiet_before_pg: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_seen_q |-> (!pcif_out && !buf_out && oth_out == '0 && !cput_oe && !cpuc_oe));

    a_r3_freq_held: assert property (@(posedge clk) disable iff (!rst_n)
        run_seen_q |=> $stable(freq_sel));

    a_r10_pcif_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pcif_out) |-> !$past(pcif_src));

    a_r10_buf_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_out) |-> !$past(buf_src));

    a_r10_pcif_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcif_out) |-> $past(pcif_src));

    a_r8_pll_off_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> (!pcif_out && !buf_out && oth_out == '0 && cput_out && !cpuc_oe));

    a_r7_parked_while_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (cput_out && !cpuc_oe));
endmodule

bind clkgen_pwr_seq clkgen_pwr_seq_chk #(.N_OTH(N_OTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_n     (pg_n),
    .pcif_src (pcif_src),
    .buf_src  (buf_src),
    .pcif_out (pcif_out),
    .buf_out  (buf_out),
    .oth_out  (oth_out),
    .cput_out (cput_out),
    .cput_oe  (cput_oe),
    .cpuc_oe  (cpuc_oe),
    .pll_en   (pll_en),
    .freq_sel (freq_sel)
);

// File: tb/clkgen_pwr_seq_test.sv
module clkgen_pwr_seq_test;
    localparam int N_OTH   = 3;
    localparam int SETTLE  = 40;
    localparam int RESTART = 60;
    localparam int HALF_CPU  = 2;
    localparam int HALF_PCIF = 5;
    localparam int HALF_BUF  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             pg_n = 1'b1;
    logic             pd_n = 1'b1;
    logic             s1 = 1'b0;
    logic [1:0]       s2_lvl = 2'b00;
    logic             park_tri = 1'b0;
    logic             cpu_src = 1'b0;
    logic             pcif_src = 1'b0;
    logic             buf_src = 1'b0;
    logic [N_OTH-1:0] oth_src = '0;
    logic             cput_out, cput_oe, cpuc_out, cpuc_oe;
    logic             pcif_out, buf_out, pll_en;
    logic [N_OTH-1:0] oth_out;
    logic [1:0]       freq_sel;

    clkgen_pwr_seq #(.N_OTH(N_OTH), .SETTLE_CYC(SETTLE), .RESTART_CYC(RESTART)) uut (
        .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .pd_n(pd_n), .s1(s1), .s2_lvl(s2_lvl),
        .park_tri(park_tri), .cpu_src(cpu_src), .pcif_src(pcif_src), .buf_src(buf_src),
        .oth_src(oth_src), .cput_out(cput_out), .cput_oe(cput_oe), .cpuc_out(cpuc_out),
        .cpuc_oe(cpuc_oe), .pcif_out(pcif_out), .buf_out(buf_out), .oth_out(oth_out),
        .pll_en(pll_en), .freq_sel(freq_sel)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    function automatic int oth_half(input int i);
        return (i == 0) ? 4 : (i == 1) ? 7 : 6;
    endfunction

    function automatic logic [1:0] exp_freq(input logic [1:0] s2, input logic s1v);
        return {(s2 == 2'b01), s1v};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitors: falls, pulse widths
    int hl_p = 0, hl_b = 0;
    int hl_o [N_OTH];
    int last_p = 0, last_b = 0;
    int last_o [N_OTH];
    int tog_p = 0, tog_b = 0, tog_o [N_OTH];
    int glitches = 0;
    logic out_prev [N_OTH];

    initial begin
        for (int i = 0; i < N_OTH; i++) begin
            hl_o[i] = 0; last_o[i] = 0; tog_o[i] = 0;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        cpu_src  = ((cyc / HALF_CPU) % 2) == 1;
        pcif_src = ((cyc / HALF_PCIF) % 2) == 1;
        buf_src  = ((cyc / HALF_BUF) % 2) == 1;
        for (int i = 0; i < N_OTH; i++) oth_src[i] = ((cyc / oth_half(i)) % 2) == 1;
        if (pcif_out) hl_p++;
        else if (hl_p != 0) begin
            if (hl_p != HALF_PCIF) glitches++;
            hl_p = 0; last_p = cyc; tog_p++;
        end
        if (buf_out) hl_b++;
        else if (hl_b != 0) begin
            if (hl_b != HALF_BUF) glitches++;
            hl_b = 0; last_b = cyc; tog_b++;
        end
        for (int i = 0; i < N_OTH; i++) begin
            if (oth_out[i]) hl_o[i]++;
            else if (hl_o[i] != 0) begin
                if (hl_o[i] != oth_half(i)) glitches++;
                hl_o[i] = 0; last_o[i] = cyc; tog_o[i]++;
            end
        end
    end

    function automatic int min_tog();
        int m = (tog_p < tog_b) ? tog_p : tog_b;
        for (int i = 0; i < N_OTH; i++) if (tog_o[i] < m) m = tog_o[i];
        return m;
    endfunction

    function automatic int sum_tog();
        int s = tog_p + tog_b;
        for (int i = 0; i < N_OTH; i++) s += tog_o[i];
        return s;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [1:0] exp_f;
        int t_snap, base;
        void'($urandom(32'd4242));
        wait_cyc(3);
        // R1: reset state
        chk(pcif_out == 0 && buf_out == 0 && oth_out == 0, "R1 outputs gated", int'(pcif_out), 0);
        chk(cput_oe == 0 && cpuc_oe == 0, "R1 cpu undriven", int'(cput_oe), 0);
        chk(pll_en == 1 && freq_sel == 0, "R1 pll and straps", int'(pll_en), 1);
        rst_n = 1'b1;
        wait_cyc(50);
        // R2: nothing before power-good
        chk(sum_tog() == 0 && !cput_oe, "R2 quiet without pg", sum_tog(), 0);
        // R3: mid code on s2 latches 0
        s2_lvl = 2'b10;
        s1 = 1'($urandom_range(0, 1));
        exp_f = exp_freq(s2_lvl, s1);
        pg_n = 1'b0;
        wait_cyc(30);
        chk(sum_tog() == 0 && !cput_oe, "R2 quiet during settle", sum_tog(), 0);
        wait_cyc(60);
        chk(min_tog() > 0, "R2 outputs running after settle", min_tog(), 1);
        chk(cput_oe && cpuc_oe, "R2 cpu driven after settle", int'(cput_oe), 1);
        chk(freq_sel == exp_f && freq_sel[1] == 1'b0, "R3 mid strap latched as 0", int'(freq_sel), int'(exp_f));
        // R3/R4: later strap and power-good changes ignored
        s2_lvl = 2'b01;
        s1 = ~s1;
        pg_n = 1'b1;
        t_snap = sum_tog();
        wait_cyc(40);
        chk(freq_sel == exp_f, "R3 straps not resampled", int'(freq_sel), int'(exp_f));
        chk(sum_tog() > t_snap, "R4 pg high ignored", sum_tog(), t_snap + 1);
        pg_n = 1'b0;
        wait_cyc(10);
        pg_n = 1'b1;
        wait_cyc(10);
        chk(freq_sel == exp_f && pll_en, "R4 pg toggle ignored", int'(freq_sel), int'(exp_f));
        // R5: short pulse covers at most one complement rise
        pd_n = 1'b0;
        wait_cyc(2);
        pd_n = 1'b1;
        t_snap = min_tog();
        wait_cyc(50);
        chk(pll_en == 1, "R5 short pulse ignored pll", int'(pll_en), 1);
        chk(min_tog() > t_snap, "R5 short pulse ignored clocks", min_tog(), t_snap + 1);
        // full power-down cycles
        for (int it = 0; it < 4; it++) begin
            int off_cyc, mx, w, tri_v;
            tri_v = (it == 0) ? 0 : (it == 1) ? 1 : int'($urandom_range(0, 1));
            park_tri = 1'(tri_v);
            wait_cyc(int'($urandom_range(1, 17)));
            pd_n = 1'b0;
            w = 0;
            while (pll_en && w < 400) begin
                wait_cyc(1);
                w++;
            end
            off_cyc = cyc;
            chk(!pll_en, "R8 pll shut down", int'(pll_en), 0);
            chk(last_p < last_b, "R6 pcif before buf", last_p, last_b);
            mx = last_b;
            for (int i = 0; i < N_OTH; i++) begin
                chk(last_b < last_o[i], "R6 buf before other", last_b, last_o[i]);
                if (last_o[i] > mx) mx = last_o[i];
            end
            chk(mx <= off_cyc, "R8 pll off after last stop", mx, off_cyc);
            chk(cput_out && !cpuc_oe && cput_oe == !park_tri, "R7 cpu park", int'(cput_oe), int'(!park_tri));
            park_tri = ~park_tri;
            t_snap = sum_tog();
            wait_cyc(12);
            chk(sum_tog() == t_snap && !pcif_out && oth_out == 0, "R6 all held low", sum_tog(), t_snap);
            chk(cput_oe == park_tri, "R7 park select captured", int'(cput_oe), int'(park_tri));
            pd_n = 1'b1;
            base = sum_tog();
            wait_cyc(4);
            chk(pll_en, "R9 pll back on", int'(pll_en), 1);
            wait_cyc(RESTART - 5);
            chk(sum_tog() == base && !pcif_out, "R9 no early restart", sum_tog(), base);
            t_snap = min_tog();
            wait_cyc(40);
            chk(min_tog() > t_snap && cpuc_oe, "R9 restart within timeout", min_tog(), t_snap + 1);
        end
        chk(glitches == 0, "R10 full-width pulses", glitches, 0);
        summary();
        $finish;
    end
endmodule